// File: doc/BRIEF.md
# Reset-Time Bypass Transceiver

This block sits between two data ports of a dual-port buffer and takes over the data path while the hold input (`hold_n`, active low) is held low. During that window the buffer storage is skipped. Port A, the master, is the only side that can start a transfer. Each transfer is registered and captured on the rising edge of `clk_a`.

The direction comes from port A's read/write select, and the hold input never overrides it. A write (`a_rnw` = 0) moves the word on `a_din` to port B. A read (`a_rnw` = 1) moves the word on `b_din` back to port A. Port B has no controls of its own in this mode; its data is sampled on the master's clock. A controller can use this path to pass setup words to a peripheral before normal operation begins.

A second function judges whether the hold was long enough to count as a proper initialization. Both port clocks must show a rising and a falling edge while `hold_n` is low. The result is reported on `reset_done`, and buffer writes are allowed only once that flag is set and the hold has been released.

Top module: `rst_bypass_xcvr`

## Requirements
- R1: While `hold_n` is low, a rising `clk_a` edge with `a_en` = 1, `a_req` = 1 and `a_rnw` = 0 loads `a_din` into `b_dout`, sets `b_oe` = 1 and clears `a_oe`. The outputs show this after that edge.
- R2: While `hold_n` is low, a rising `clk_a` edge with `a_en` = 1, `a_req` = 1 and `a_rnw` = 1 loads `b_din` into `a_dout`, sets `a_oe` = 1 and clears `b_oe`.
- R3: While `hold_n` is low, a `clk_a` edge where `a_en` or `a_req` is 0 leaves `a_dout`, `b_dout`, `a_oe` and `b_oe` unchanged.
- R4: `a_oe` and `b_oe` are never 1 at the same time.
- R5: When `hold_n` goes high, the following happens at once, without waiting for a clock edge:
  - `a_oe` and `b_oe` drop to 0.
  - Both data outputs clear to zero.
  - They stay that way while `hold_n` is high, whatever port A requests.
- R6: At the first rising `clk_a` edge of a hold, `reset_done` goes to 0. It rises again only after a rising and a falling edge of each clock have occurred during the hold. The result from port B is delayed by `SYNC_STAGES` cycles of `clk_a`.
- R7: `reset_done` does not change while `hold_n` is high. A hold spanning only one rising `clk_a` edge therefore leaves it at 0 after release.
- R8: `fifo_wr_allow` is 1 exactly when `hold_n` is high and `reset_done` is 1.
- R9: The direction is taken from `a_rnw` on every transfer edge, so consecutive transfers may alternate between directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Master port clock; all transfers are captured on its rising edge |
| clk_b | input | 1 | Slave port clock; used only to qualify the hold |
| hold_n | input | 1 | Active-low hold; low selects bypass mode |
| a_en | input | 1 | Port A enable |
| a_req | input | 1 | Port A request |
| a_rnw | input | 1 | Port A direction: 0 = A to B, 1 = B to A |
| a_din | input | W | Word presented by port A |
| a_dout | output | W | Registered word delivered to port A |
| a_oe | output | 1 | Port A output drive enable |
| b_din | input | W | Word presented by port B |
| b_dout | output | W | Registered word delivered to port B |
| b_oe | output | 1 | Port B output drive enable |
| reset_done | output | 1 | The hold met the edge conditions on both clocks |
| fifo_wr_allow | output | 1 | Buffer writes permitted |

## Verification
The checker evaluates the following on every rising `clk_a` edge:
- the transfer in each direction;
- that outputs do not move on edges without a request;
- that the two drive enables are exclusive;
- that nothing drives once the hold has ended;
- that `reset_done` stays frozen outside a hold.

The bench scenarios cover what a single-clock property cannot see well:
- the asynchronous drop of the enables when the hold is released;
- a hold too short to qualify;
- `reset_done` being withdrawn at the start of a new hold and set again once both clocks have toggled.

// File: rtl/rbx_pkg.sv
package rbx_pkg;

    typedef enum logic {
        DIR_A2B = 1'b0,
        DIR_B2A = 1'b1
    } xfer_dir_e;

    typedef struct packed {
        logic rise_a;
        logic fall_a;
        logic rise_b;
        logic fall_b;
    } edge_seen_t;

    function automatic xfer_dir_e dir_of(input logic rnw);
        return rnw ? DIR_B2A : DIR_A2B;
    endfunction

    function automatic logic all_seen(input edge_seen_t s);
        return &s;
    endfunction

endpackage

// File: rtl/hold_edge_mark.sv
// Remembers whether the hold input was low at the most recent clock edge
// of the selected polarity.
module hold_edge_mark #(
    parameter bit NEG_EDGE = 1'b0
) (
    input  logic clk,
    input  logic hold_n,
    output logic seen
);
    generate
        if (NEG_EDGE) begin : g_neg
            always_ff @(negedge clk) begin
                seen <= ~hold_n;
            end
        end else begin : g_pos
            always_ff @(posedge clk) begin
                seen <= ~hold_n;
            end
        end
    endgenerate
endmodule

// File: rtl/flag_sync.sv
// Multi-stage synchronizer for a single flag.
module flag_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                chain <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/reset_qual.sv
// Decides whether the current hold has seen both edges of both clocks.
module reset_qual
    import rbx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_a,
    input  logic clk_b,
    input  logic hold_n,
    output logic reset_done
);
    localparam int NB = 2;

    logic       rise_a_raw;
    logic       fall_a_raw;
    logic [NB-1:0] b_raw;
    logic [NB-1:0] b_sync;
    edge_seen_t seen_s;

    hold_edge_mark #(.NEG_EDGE(1'b0)) u_mark_ra (.clk(clk_a), .hold_n(hold_n), .seen(rise_a_raw));
    hold_edge_mark #(.NEG_EDGE(1'b1)) u_mark_fa (.clk(clk_a), .hold_n(hold_n), .seen(fall_a_raw));

    genvar gi;
    generate
        for (gi = 0; gi < NB; gi++) begin : g_bside
            hold_edge_mark #(.NEG_EDGE(gi == 1)) u_mark (
                .clk(clk_b), .hold_n(hold_n), .seen(b_raw[gi])
            );
            flag_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk(clk_a), .d(b_raw[gi]), .q(b_sync[gi])
            );
        end
    endgenerate

    always_comb begin
        seen_s.rise_a = rise_a_raw;
        seen_s.fall_a = fall_a_raw;
        seen_s.rise_b = b_sync[0];
        seen_s.fall_b = b_sync[1];
    end

    // Re-evaluated only during a hold; frozen once released.
    always_ff @(posedge clk_a) begin
        if (!hold_n) begin
            reset_done <= all_seen(seen_s);
        end
    end
endmodule

// File: rtl/bypass_path.sv
// Registered data path between the ports, active while the hold is low.
module bypass_path
    import rbx_pkg::*;
#(
    parameter int W = 36
) (
    input  logic         clk_a,
    input  logic         hold_n,
    input  logic         a_en,
    input  logic         a_req,
    input  logic         a_rnw,
    input  logic [W-1:0] a_din,
    input  logic [W-1:0] b_din,
    output logic [W-1:0] a_dout,
    output logic         a_oe,
    output logic [W-1:0] b_dout,
    output logic         b_oe
);
    always_ff @(posedge clk_a or posedge hold_n) begin
        if (hold_n) begin
            a_dout <= '0;
            b_dout <= '0;
            a_oe   <= 1'b0;
            b_oe   <= 1'b0;
        end else if (a_en && a_req) begin
            case (dir_of(a_rnw))
                DIR_A2B: begin
                    b_dout <= a_din;
                    b_oe   <= 1'b1;
                    a_oe   <= 1'b0;
                end
                DIR_B2A: begin
                    a_dout <= b_din;
                    a_oe   <= 1'b1;
                    b_oe   <= 1'b0;
                end
                default: begin
                    a_oe <= 1'b0;
                    b_oe <= 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/rst_bypass_xcvr.sv
module rst_bypass_xcvr #(
    parameter int W           = 36,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk_a,
    input  logic         clk_b,
    input  logic         hold_n,
    input  logic         a_en,
    input  logic         a_req,
    input  logic         a_rnw,
    input  logic [W-1:0] a_din,
    output logic [W-1:0] a_dout,
    output logic         a_oe,
    input  logic [W-1:0] b_din,
    output logic [W-1:0] b_dout,
    output logic         b_oe,
    output logic         reset_done,
    output logic         fifo_wr_allow
);
    bypass_path #(.W(W)) u_path (
        .clk_a (clk_a),
        .hold_n(hold_n),
        .a_en  (a_en),
        .a_req (a_req),
        .a_rnw (a_rnw),
        .a_din (a_din),
        .b_din (b_din),
        .a_dout(a_dout),
        .a_oe  (a_oe),
        .b_dout(b_dout),
        .b_oe  (b_oe)
    );

    reset_qual #(.SYNC_STAGES(SYNC_STAGES)) u_qual (
        .clk_a     (clk_a),
        .clk_b     (clk_b),
        .hold_n    (hold_n),
        .reset_done(reset_done)
    );

    assign fifo_wr_allow = hold_n & reset_done;
endmodule

// File: rtl/rst_bypass_xcvr_chk.sv
module rst_bypass_xcvr_chk #(
    parameter int W = 36
) (
    input logic         clk_a,
    input logic         hold_n,
    input logic         a_en,
    input logic         a_req,
    input logic         a_rnw,
    input logic [W-1:0] a_din,
    input logic [W-1:0] a_dout,
    input logic         a_oe,
    input logic [W-1:0] b_din,
    input logic [W-1:0] b_dout,
    input logic         b_oe,
    input logic         reset_done
);
    // R1
    a2b_xfer_chk: assert property (@(posedge clk_a) disable iff (hold_n)
        (a_en && a_req && !a_rnw) |=> (b_dout == $past(a_din) && b_oe && !a_oe));

    // R2
    b2a_xfer_chk: assert property (@(posedge clk_a) disable iff (hold_n)
        (a_en && a_req && a_rnw) |=> (a_dout == $past(b_din) && a_oe && !b_oe));

    // R3
    idle_hold_chk: assert property (@(posedge clk_a) disable iff (hold_n)
        !(a_en && a_req) |=> ($stable(a_dout) && $stable(b_dout) && $stable(a_oe) && $stable(b_oe)));

    // R4
    oe_excl_chk: assert property (@(posedge clk_a) disable iff (hold_n)
        !(a_oe && b_oe));

    // R5
    released_quiet_chk: assert property (@(posedge clk_a) disable iff (!hold_n)
        hold_n |-> (!a_oe && !b_oe && a_dout == '0 && b_dout == '0));

    // R7
    done_frozen_chk: assert property (@(posedge clk_a) disable iff (!hold_n)
        hold_n |=> $stable(reset_done));
endmodule

bind rst_bypass_xcvr rst_bypass_xcvr_chk #(.W(W)) u_chk (
    .clk_a     (clk_a),
    .hold_n    (hold_n),
    .a_en      (a_en),
    .a_req     (a_req),
    .a_rnw     (a_rnw),
    .a_din     (a_din),
    .a_dout    (a_dout),
    .a_oe      (a_oe),
    .b_din     (b_din),
    .b_dout    (b_dout),
    .b_oe      (b_oe),
    .reset_done(reset_done)
);

// File: tb/tb_rst_bypass_xcvr.sv
module tb_rst_bypass_xcvr;
    localparam int W = 36;

    logic         clk_a = 1'b0;
    logic         clk_b = 1'b0;
    logic         hold_n;
    logic         a_en, a_req, a_rnw;
    logic [W-1:0] a_din, b_din;
    logic [W-1:0] a_dout, b_dout;
    logic         a_oe, b_oe, reset_done, fifo_wr_allow;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk_a = ~clk_a;
    always #13 clk_b = ~clk_b;

    rst_bypass_xcvr #(.W(W), .SYNC_STAGES(2)) dut (
        .clk_a(clk_a), .clk_b(clk_b), .hold_n(hold_n),
        .a_en(a_en), .a_req(a_req), .a_rnw(a_rnw),
        .a_din(a_din), .a_dout(a_dout), .a_oe(a_oe),
        .b_din(b_din), .b_dout(b_dout), .b_oe(b_oe),
        .reset_done(reset_done), .fifo_wr_allow(fifo_wr_allow)
    );

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // wait past a rising clk_a edge, then settle just after the falling edge
    task automatic tick();
        @(negedge clk_a);
        #1;
    endtask

    task automatic t_reset_state();
        tick();
        check("R5 a_oe idle at start", W'(a_oe), '0);
        check("R5 b_oe idle at start", W'(b_oe), '0);
        check("R5 b_dout cleared", b_dout, '0);
        check("R8 no write during hold", W'(fifo_wr_allow), '0);
        repeat (8) tick();
        check("R6 qualified after both clocks toggled", W'(reset_done), 1);
        check("R8 still blocked while held", W'(fifo_wr_allow), '0);
    endtask

    task automatic t_write();
        a_en = 1; a_req = 1; a_rnw = 0; a_din = 36'h1_2345_6789;
        tick();
        check("R1 b_dout", b_dout, 36'h1_2345_6789);
        check("R1 b_oe", W'(b_oe), 1);
        check("R4 a_oe off on write", W'(a_oe), 0);
        a_en = 0;
    endtask

    task automatic t_read();
        b_din = 36'hA_5A50_F0F1; a_en = 1; a_req = 1; a_rnw = 1;
        tick();
        check("R2 a_dout", a_dout, 36'hA_5A50_F0F1);
        check("R2 a_oe", W'(a_oe), 1);
        check("R4 b_oe off on read", W'(b_oe), 0);
        a_en = 0;
    endtask

    task automatic t_idle();
        a_en = 1; a_req = 0; a_rnw = 0; a_din = 36'hF_FFFF_0000;
        tick();
        check("R3 b_dout held (req low)", b_dout, 36'h1_2345_6789);
        check("R3 a_oe held (req low)", W'(a_oe), 1);
        a_en = 0; a_req = 1; b_din = 36'h0_0000_1111; a_rnw = 1;
        tick();
        check("R3 a_dout held (en low)", a_dout, 36'hA_5A50_F0F1);
        check("R3 b_oe held (en low)", W'(b_oe), 0);
        a_req = 0;
    endtask

    task automatic t_alternate();
        for (int i = 0; i < 4; i++) begin
            logic [W-1:0] va, vb;
            va = 36'h0_F0F0_F0F0 ^ W'(i * 16'h1357);
            vb = 36'hC_3C3C_3C3C + W'(i);
            a_din = va; b_din = vb; a_en = 1; a_req = 1; a_rnw = i[0];
            tick();
            if (i[0]) begin
                check("R9 alternating read data", a_dout, vb);
                check("R9 alternating read oe", W'({a_oe, b_oe}), 2'b10);
            end else begin
                check("R9 alternating write data", b_dout, va);
                check("R9 alternating write oe", W'({a_oe, b_oe}), 2'b01);
            end
        end
        a_en = 0; a_req = 0;
    endtask

    task automatic t_release();
        hold_n = 1;
        #2;
        check("R5 drive stops at once", W'({a_oe, b_oe}), 0);
        check("R5 a_dout cleared", a_dout, '0);
        check("R8 writes allowed after good hold", W'(fifo_wr_allow), 1);
        a_en = 1; a_req = 1; a_rnw = 0; a_din = 36'h7_7777_7777;
        tick();
        check("R5 request ignored after release", b_dout, '0);
        check("R5 no drive after release", W'(b_oe), 0);
        a_en = 0; a_req = 0;
        repeat (3) tick();
        check("R7 done kept while released", W'(reset_done), 1);
    endtask

    task automatic t_short_hold();
        hold_n = 0;
        tick();
        hold_n = 1;
        #1;
        check("R6 short hold clears done", W'(reset_done), 0);
        check("R8 short hold blocks writes", W'(fifo_wr_allow), 0);
        repeat (4) tick();
        check("R7 done stays low while released", W'(reset_done), 0);
    endtask

    task automatic t_requalify();
        hold_n = 0;
        tick();
        check("R6 done low after first edge of hold", W'(reset_done), 0);
        repeat (8) tick();
        check("R6 requalified", W'(reset_done), 1);
        hold_n = 1;
        #1;
        check("R8 writes allowed again", W'(fifo_wr_allow), 1);
    endtask

    initial begin
        a_en = 0; a_req = 0; a_rnw = 0; a_din = '0; b_din = '0;
        hold_n = 0;
        #1 hold_n = 1;
        #1 hold_n = 0;
        t_reset_state();
        t_write();
        t_read();
        t_idle();
        t_alternate();
        t_release();
        t_short_hold();
        t_requalify();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule